// File: doc/BRIEF.md
# I2C-Configured Pad Router and Display Polarity Block

This block is a small configuration target on an I2C bus. A host writes a one-byte register pointer and then data bytes. Two writable registers live behind that pointer:

- A display-control byte. It flips the polarity of the pixel clock, the two sync strobes and data-enable, picks the active pixel width, and raises a converter-enable line.
- A routing byte. It steers a serial peripheral's four SPI signals, or a UART pair, onto one of several external pad groups. Each pad group has its own slot order.

Two more locations are read-only constants: an identity byte and a firmware version byte.

The bus pins are sampled with the block clock. SDA is only ever pulled low. SCL is never driven. Every pad output is a data/enable pair. A pad whose enable is low is treated as tri-stated by the pad ring.

Top module: `pinroute_cfg_top`

## Requirements
- R1: The target acknowledges 7-bit address 0x41. A transaction to any other address gets no acknowledge and changes no register.
- R2: In a write, the first data byte after the address loads the register pointer, and every later byte is written to that same pointer. A read after a repeated start returns the pointed-to register, and every further byte of the same read returns that register again.
- R3: Location 0x00 reads 0x61 and location 0xF0 reads 0x01. Writes to either are ignored. Any location other than 0x00, 0x10, 0x20 and 0xF0 reads 0x00 and is still acknowledged.
- R4: After reset, the display byte (location 0x10) and the routing byte (location 0x20) both read 0x00. Both read back exactly as written.
- R5: In the display byte, bit 7 inverts the pixel clock, bit 6 inverts HSync, bit 5 inverts VSync and bit 4 inverts data-enable. Each is applied as an XOR on the matching input.
- R6: Display bits 3:2 set the pixel width: 2'b11 passes data bits 23..0, 2'b10 passes 17..0, 2'b01 passes 15..0 and 2'b00 passes none. Bits that are not passed are driven 0. Bit 0 drives the converter-enable output.
- R7: When routing low nibble is 0 or 5..15:
  - every pad enable is low and every pad data output is 0;
  - the core MISO input is 0;
  - the core UART receive input idles at 1.
- R8: Routing value 1 sends UART transmit to the radio pad with its enable high, and returns the radio receive pad to the core UART receive.
- R9: Routing value 2 uses group A. Slot 0 is SS, slot 1 CLK, slot 2 MISO (input) and slot 3 MOSI. Bit n of a group's vectors is slot n.
- R10: Routing value 3 uses group B. Slot 0 is MOSI, slot 1 CLK, slot 2 SS and slot 3 MISO (input).
- R11: Routing value 4 uses group B. Slot 0 is MISO (input), slot 1 SS, slot 2 CLK and slot 3 MOSI.
- R12: A MISO slot never has its enable high. Output slots carry the core signal, and unused pad data outputs are 0. At most one of the radio pad, group A and group B is enabled at a time.
- R13: The target changes its SDA pull-down only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | High pulls SDA low |
| uart_tx_i | input | 1 | Core UART transmit |
| uart_rx_o | output | 1 | Core UART receive |
| radio_tx_o | output | 1 | Radio pad transmit data |
| radio_tx_oe | output | 1 | Radio pad transmit enable |
| radio_rx_i | input | 1 | Radio pad receive |
| spi_ss_i | input | 1 | Core SPI select |
| spi_clk_i | input | 1 | Core SPI clock |
| spi_mosi_i | input | 1 | Core SPI data out |
| spi_miso_o | output | 1 | Core SPI data in |
| pa_out | output | 4 | Group A pad data |
| pa_oe | output | 4 | Group A pad enables |
| pa_in | input | 4 | Group A pad inputs |
| pb_out | output | 4 | Group B pad data |
| pb_oe | output | 4 | Group B pad enables |
| pb_in | input | 4 | Group B pad inputs |
| dsp_pclk_i | input | 1 | Incoming pixel clock |
| dsp_hs_i | input | 1 | Incoming HSync |
| dsp_vs_i | input | 1 | Incoming VSync |
| dsp_de_i | input | 1 | Incoming data-enable |
| dsp_data_i | input | 24 | Incoming pixel data |
| lcd_pclk_o | output | 1 | Polarity-adjusted pixel clock |
| lcd_hs_o | output | 1 | Polarity-adjusted HSync |
| lcd_vs_o | output | 1 | Polarity-adjusted VSync |
| lcd_de_o | output | 1 | Polarity-adjusted data-enable |
| lcd_data_o | output | 24 | Width-masked pixel data |
| conv_en_o | output | 1 | Converter enable |

## Verification
The SDA check assumes a conforming bus master. Such a master:
- holds SCL high for at least a few block clocks;
- changes SDA only while SCL is low, except to signal a start or a stop;
- never issues a start or stop while the target holds SDA low.

The bench's bit-level master keeps every SCL phase six clocks long. It moves SDA only inside the low phase, except for its start and stop patterns, and it releases SDA in every acknowledge and read slot. The routing and polarity properties rest only on register state and pad inputs. Those inputs are held steady between checks while the sweeps walk every routing value and every combination of polarity flags and width code.

// File: rtl/pinroute_cfg_pkg.sv
package pinroute_cfg_pkg;

    localparam logic [6:0] DEV_ADDR   = 7'h41;
    localparam logic [7:0] ID_VALUE   = 8'h61;
    localparam logic [7:0] FW_VERSION = 8'h01;

    localparam logic [7:0] LOC_ID    = 8'h00;
    localparam logic [7:0] LOC_DISP  = 8'h10;
    localparam logic [7:0] LOC_ROUTE = 8'h20;
    localparam logic [7:0] LOC_VER   = 8'hF0;

    localparam int PIX_W     = 24;
    localparam int PAD_SLOTS = 4;

    typedef enum logic [2:0] {
        TS_IDLE,
        TS_ADDR,
        TS_AACK,
        TS_WDATA,
        TS_WACK,
        TS_RDATA,
        TS_RACK
    } tgt_state_e;

    typedef enum logic [2:0] {
        RT_NONE,
        RT_UART,
        RT_SPI_A,
        RT_SPI_B_ALT1,
        RT_SPI_B_ALT2
    } route_e;

    typedef enum logic [2:0] {
        SG_NONE,
        SG_SS,
        SG_CLK,
        SG_MOSI,
        SG_MISO
    } sig_e;

    typedef enum logic {
        GRP_A,
        GRP_B
    } grp_e;

    typedef struct packed {
        logic       inv_pclk;
        logic       inv_hs;
        logic       inv_vs;
        logic       inv_de;
        logic [1:0] fmt;
        logic       spare;
        logic       enable;
    } disp_cfg_t;

    function automatic route_e route_decode(input logic [3:0] nib);
        case (nib)
            4'd1:    return RT_UART;
            4'd2:    return RT_SPI_A;
            4'd3:    return RT_SPI_B_ALT1;
            4'd4:    return RT_SPI_B_ALT2;
            default: return RT_NONE;
        endcase
    endfunction

    function automatic sig_e slot_signal(input route_e rt, input grp_e g, input int slot);
        sig_e s;
        s = SG_NONE;
        if (g == GRP_A && rt == RT_SPI_A) begin
            case (slot)
                0: s = SG_SS;
                1: s = SG_CLK;
                2: s = SG_MISO;
                3: s = SG_MOSI;
                default: s = SG_NONE;
            endcase
        end else if (g == GRP_B && rt == RT_SPI_B_ALT1) begin
            case (slot)
                0: s = SG_MOSI;
                1: s = SG_CLK;
                2: s = SG_SS;
                3: s = SG_MISO;
                default: s = SG_NONE;
            endcase
        end else if (g == GRP_B && rt == RT_SPI_B_ALT2) begin
            case (slot)
                0: s = SG_MISO;
                1: s = SG_SS;
                2: s = SG_CLK;
                3: s = SG_MOSI;
                default: s = SG_NONE;
            endcase
        end
        return s;
    endfunction

    function automatic int fmt_width(input logic [1:0] fmt);
        case (fmt)
            2'b11:   return 24;
            2'b10:   return 18;
            2'b01:   return 16;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/pinroute_i2c_tgt.sv
module pinroute_i2c_tgt
    import pinroute_cfg_pkg::*;
#(
    parameter logic [6:0] ADDR   = DEV_ADDR,
    parameter int         BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] ptr,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_data,
    input  logic [BYTE_W-1:0] rd_data
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [1:0] scl_sync, sda_sync;
    logic       scl_p, sda_p;
    logic       scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sync <= 2'b11;
            sda_sync <= 2'b11;
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[0], scl_i};
            sda_sync <= {sda_sync[0], sda_i};
            scl_p    <= scl_sync[1];
            sda_p    <= sda_sync[1];
        end
    end

    assign scl_q = scl_sync[1];
    assign sda_q = sda_sync[1];

    logic ev_start, ev_stop, ev_rise, ev_fall;
    assign ev_start = scl_q && scl_p && sda_p && !sda_q;
    assign ev_stop  = scl_q && scl_p && !sda_p && sda_q;
    assign ev_rise  = scl_q && !scl_p;
    assign ev_fall  = !scl_q && scl_p;

    tgt_state_e        state;
    logic [BYTE_W-1:0] sh;
    logic [CNT_W-1:0]  bitcnt;
    logic              done, rw, first, nack;

    assign wr_data = sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= TS_IDLE;
            sh     <= '0;
            bitcnt <= '0;
            done   <= 1'b0;
            rw     <= 1'b0;
            first  <= 1'b0;
            nack   <= 1'b0;
            sda_oe <= 1'b0;
            ptr    <= '0;
            wr_stb <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            if (ev_start) begin
                state  <= TS_ADDR;
                bitcnt <= '0;
                done   <= 1'b0;
                first  <= 1'b1;
                sda_oe <= 1'b0;
            end else if (ev_stop) begin
                state  <= TS_IDLE;
                sda_oe <= 1'b0;
            end else if (ev_rise) begin
                case (state)
                    TS_ADDR, TS_WDATA: begin
                        sh     <= {sh[BYTE_W-2:0], sda_q};
                        bitcnt <= bitcnt + 1'b1;
                        done   <= (bitcnt == LAST_BIT);
                    end
                    TS_RACK: nack <= sda_q;
                    default: ;
                endcase
            end else if (ev_fall) begin
                case (state)
                    TS_ADDR: begin
                        if (done) begin
                            done <= 1'b0;
                            if (sh[BYTE_W-1:1] == ADDR) begin
                                state  <= TS_AACK;
                                sda_oe <= 1'b1;
                                rw     <= sh[0];
                            end else begin
                                state <= TS_IDLE;
                            end
                        end
                    end
                    TS_AACK: begin
                        bitcnt <= '0;
                        if (rw) begin
                            state  <= TS_RDATA;
                            sh     <= rd_data;
                            sda_oe <= ~rd_data[BYTE_W-1];
                        end else begin
                            state  <= TS_WDATA;
                            sda_oe <= 1'b0;
                        end
                    end
                    TS_WDATA: begin
                        if (done) begin
                            done   <= 1'b0;
                            state  <= TS_WACK;
                            sda_oe <= 1'b1;
                            if (first) begin
                                ptr   <= sh;
                                first <= 1'b0;
                            end else begin
                                wr_stb <= 1'b1;
                            end
                        end
                    end
                    TS_WACK: begin
                        state  <= TS_WDATA;
                        sda_oe <= 1'b0;
                        bitcnt <= '0;
                    end
                    TS_RDATA: begin
                        if (bitcnt == LAST_BIT) begin
                            state  <= TS_RACK;
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                        end else begin
                            sda_oe <= ~sh[BYTE_W-2];
                            sh     <= {sh[BYTE_W-2:0], 1'b0};
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                    TS_RACK: begin
                        if (nack) begin
                            state <= TS_IDLE;
                        end else begin
                            state  <= TS_RDATA;
                            sh     <= rd_data;
                            sda_oe <= ~rd_data[BYTE_W-1];
                            bitcnt <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/pinroute_cfg_regs.sv
module pinroute_cfg_regs
    import pinroute_cfg_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] ptr,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] disp_q,
    output logic [BYTE_W-1:0] route_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            disp_q  <= '0;
            route_q <= '0;
        end else if (wr_stb) begin
            case (ptr)
                LOC_DISP:  disp_q  <= wr_data;
                LOC_ROUTE: route_q <= wr_data;
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (ptr)
            LOC_ID:    rd_data = ID_VALUE;
            LOC_DISP:  rd_data = disp_q;
            LOC_ROUTE: rd_data = route_q;
            LOC_VER:   rd_data = FW_VERSION;
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/pinroute_pad_xbar.sv
module pinroute_pad_xbar
    import pinroute_cfg_pkg::*;
#(
    parameter int SLOTS = PAD_SLOTS
) (
    input  logic [3:0]       route_nib,
    input  logic             uart_tx_i,
    output logic             uart_rx_o,
    output logic             radio_tx_o,
    output logic             radio_tx_oe,
    input  logic             radio_rx_i,
    input  logic             spi_ss_i,
    input  logic             spi_clk_i,
    input  logic             spi_mosi_i,
    output logic             spi_miso_o,
    output logic [SLOTS-1:0] pa_out,
    output logic [SLOTS-1:0] pa_oe,
    input  logic [SLOTS-1:0] pa_in,
    output logic [SLOTS-1:0] pb_out,
    output logic [SLOTS-1:0] pb_oe,
    input  logic [SLOTS-1:0] pb_in
);
    route_e rt;
    assign rt = route_decode(route_nib);

    sig_e sel_a [SLOTS];
    sig_e sel_b [SLOTS];

    function automatic logic drive_val(input sig_e s, input logic ss, input logic ck, input logic mo);
        case (s)
            SG_SS:   return ss;
            SG_CLK:  return ck;
            SG_MOSI: return mo;
            default: return 1'b0;
        endcase
    endfunction

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign sel_a[g]  = slot_signal(rt, GRP_A, g);
        assign sel_b[g]  = slot_signal(rt, GRP_B, g);
        assign pa_out[g] = drive_val(sel_a[g], spi_ss_i, spi_clk_i, spi_mosi_i);
        assign pb_out[g] = drive_val(sel_b[g], spi_ss_i, spi_clk_i, spi_mosi_i);
        assign pa_oe[g]  = (sel_a[g] != SG_NONE) && (sel_a[g] != SG_MISO);
        assign pb_oe[g]  = (sel_b[g] != SG_NONE) && (sel_b[g] != SG_MISO);
    end

    always_comb begin
        spi_miso_o = 1'b0;
        for (int k = 0; k < SLOTS; k++) begin
            if (sel_a[k] == SG_MISO) spi_miso_o = pa_in[k];
            if (sel_b[k] == SG_MISO) spi_miso_o = pb_in[k];
        end
    end

    assign radio_tx_oe = (rt == RT_UART);
    assign radio_tx_o  = (rt == RT_UART) ? uart_tx_i : 1'b0;
    assign uart_rx_o   = (rt == RT_UART) ? radio_rx_i : 1'b1;

endmodule

// File: rtl/pinroute_disp_pol.sv
module pinroute_disp_pol
    import pinroute_cfg_pkg::*;
#(
    parameter int DW = PIX_W
) (
    input  logic [3:0]    inv_flags,
    input  logic [1:0]    fmt,
    input  logic          enable,
    input  logic          dsp_pclk_i,
    input  logic          dsp_hs_i,
    input  logic          dsp_vs_i,
    input  logic          dsp_de_i,
    input  logic [DW-1:0] dsp_data_i,
    output logic          lcd_pclk_o,
    output logic          lcd_hs_o,
    output logic          lcd_vs_o,
    output logic          lcd_de_o,
    output logic [DW-1:0] lcd_data_o,
    output logic          conv_en_o
);
    int active_w;
    assign active_w = fmt_width(fmt);

    assign lcd_pclk_o = dsp_pclk_i ^ inv_flags[3];
    assign lcd_hs_o   = dsp_hs_i   ^ inv_flags[2];
    assign lcd_vs_o   = dsp_vs_i   ^ inv_flags[1];
    assign lcd_de_o   = dsp_de_i   ^ inv_flags[0];
    assign conv_en_o  = enable;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign lcd_data_o[i] = (i < active_w) ? dsp_data_i[i] : 1'b0;
    end

endmodule

// File: rtl/pinroute_cfg_top.sv
module pinroute_cfg_top
    import pinroute_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    input  logic        uart_tx_i,
    output logic        uart_rx_o,
    output logic        radio_tx_o,
    output logic        radio_tx_oe,
    input  logic        radio_rx_i,
    input  logic        spi_ss_i,
    input  logic        spi_clk_i,
    input  logic        spi_mosi_i,
    output logic        spi_miso_o,
    output logic [3:0]  pa_out,
    output logic [3:0]  pa_oe,
    input  logic [3:0]  pa_in,
    output logic [3:0]  pb_out,
    output logic [3:0]  pb_oe,
    input  logic [3:0]  pb_in,
    input  logic        dsp_pclk_i,
    input  logic        dsp_hs_i,
    input  logic        dsp_vs_i,
    input  logic        dsp_de_i,
    input  logic [23:0] dsp_data_i,
    output logic        lcd_pclk_o,
    output logic        lcd_hs_o,
    output logic        lcd_vs_o,
    output logic        lcd_de_o,
    output logic [23:0] lcd_data_o,
    output logic        conv_en_o
);
    localparam int BYTE_W = 8;

    logic [BYTE_W-1:0] ptr, wr_data, rd_data, disp_q, route_q;
    logic              wr_stb;
    disp_cfg_t         dcfg;

    assign dcfg = disp_cfg_t'(disp_q);

    pinroute_i2c_tgt #(.ADDR(DEV_ADDR), .BYTE_W(BYTE_W)) u_tgt (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .sda_oe  (sda_oe),
        .ptr     (ptr),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    pinroute_cfg_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .ptr     (ptr),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .disp_q  (disp_q),
        .route_q (route_q)
    );

    pinroute_pad_xbar #(.SLOTS(PAD_SLOTS)) u_xbar (
        .route_nib   (route_q[3:0]),
        .uart_tx_i   (uart_tx_i),
        .uart_rx_o   (uart_rx_o),
        .radio_tx_o  (radio_tx_o),
        .radio_tx_oe (radio_tx_oe),
        .radio_rx_i  (radio_rx_i),
        .spi_ss_i    (spi_ss_i),
        .spi_clk_i   (spi_clk_i),
        .spi_mosi_i  (spi_mosi_i),
        .spi_miso_o  (spi_miso_o),
        .pa_out      (pa_out),
        .pa_oe       (pa_oe),
        .pa_in       (pa_in),
        .pb_out      (pb_out),
        .pb_oe       (pb_oe),
        .pb_in       (pb_in)
    );

    pinroute_disp_pol #(.DW(PIX_W)) u_disp (
        .inv_flags  ({dcfg.inv_pclk, dcfg.inv_hs, dcfg.inv_vs, dcfg.inv_de}),
        .fmt        (dcfg.fmt),
        .enable     (dcfg.enable),
        .dsp_pclk_i (dsp_pclk_i),
        .dsp_hs_i   (dsp_hs_i),
        .dsp_vs_i   (dsp_vs_i),
        .dsp_de_i   (dsp_de_i),
        .dsp_data_i (dsp_data_i),
        .lcd_pclk_o (lcd_pclk_o),
        .lcd_hs_o   (lcd_hs_o),
        .lcd_vs_o   (lcd_vs_o),
        .lcd_de_o   (lcd_de_o),
        .lcd_data_o (lcd_data_o),
        .conv_en_o  (conv_en_o)
    );

endmodule

// File: rtl/pinroute_cfg_chk.sv
module pinroute_cfg_chk (
    input logic        clk,
    input logic        rst,
    input logic        scl_i,
    input logic        sda_oe,
    input logic [7:0]  disp_q,
    input logic [7:0]  route_q,
    input logic [3:0]  pa_oe,
    input logic [3:0]  pb_oe,
    input logic        radio_tx_oe,
    input logic        dsp_hs_i,
    input logic        lcd_hs_o,
    input logic [23:0] lcd_data_o
);
    AST_REGS_CLEAR_AFTER_RESET: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (disp_q == 8'h00 && route_q == 8'h00)); // R4
    AST_HSYNC_XOR: assert property (@(posedge clk) disable iff (rst) lcd_hs_o == (dsp_hs_i ^ disp_q[6])); // R5
    AST_FMT18_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst) (disp_q[3:2] == 2'b10) |-> (lcd_data_o[23:18] == 6'd0)); // R6
    AST_UNROUTED_QUIET: assert property (@(posedge clk) disable iff (rst) (route_q[3:0] == 4'd0 || route_q[3:0] > 4'd4) |-> (pa_oe == 4'd0 && pb_oe == 4'd0 && !radio_tx_oe)); // R7
    AST_GRPA_DIR: assert property (@(posedge clk) disable iff (rst) (route_q[3:0] == 4'd2) |-> (pa_oe == 4'b1011 && pb_oe == 4'd0)); // R9
    AST_GRPB_ALT1_DIR: assert property (@(posedge clk) disable iff (rst) (route_q[3:0] == 4'd3) |-> (pb_oe == 4'b0111 && pa_oe == 4'd0)); // R10
    AST_GRPB_ALT2_DIR: assert property (@(posedge clk) disable iff (rst) (route_q[3:0] == 4'd4) |-> (pb_oe == 4'b1110 && pa_oe == 4'd0)); // R11
    AST_ONE_GROUP: assert property (@(posedge clk) disable iff (rst) $onehot0({radio_tx_oe, |pa_oe, |pb_oe})); // R12
    AST_SDA_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (rst) (scl_i && $past(scl_i) && $past(scl_i, 2) && $past(scl_i, 3)) |-> $stable(sda_oe)); // R13
endmodule

bind pinroute_cfg_top pinroute_cfg_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .scl_i       (scl_i),
    .sda_oe      (sda_oe),
    .disp_q      (disp_q),
    .route_q     (route_q),
    .pa_oe       (pa_oe),
    .pb_oe       (pb_oe),
    .radio_tx_oe (radio_tx_oe),
    .dsp_hs_i    (dsp_hs_i),
    .lcd_hs_o    (lcd_hs_o),
    .lcd_data_o  (lcd_data_o)
);

// File: tb/tb_pinroute_cfg_top.sv
module tb_pinroute_cfg_top;
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic scl = 1'b1, m_low = 1'b0;
    logic sda_oe, sda_bus;
    assign sda_bus = ~(m_low | sda_oe);

    logic uart_tx_i = 0, radio_rx_i = 0, spi_ss_i = 0, spi_clk_i = 0, spi_mosi_i = 0;
    logic uart_rx_o, radio_tx_o, radio_tx_oe, spi_miso_o;
    logic [3:0] pa_out, pa_oe, pb_out, pb_oe;
    logic [3:0] pa_in = 0, pb_in = 0;
    logic dsp_pclk_i = 0, dsp_hs_i = 0, dsp_vs_i = 0, dsp_de_i = 0;
    logic [23:0] dsp_data_i = 0, lcd_data_o;
    logic lcd_pclk_o, lcd_hs_o, lcd_vs_o, lcd_de_o, conv_en_o;

    pinroute_cfg_top dut (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .uart_tx_i(uart_tx_i), .uart_rx_o(uart_rx_o), .radio_tx_o(radio_tx_o),
        .radio_tx_oe(radio_tx_oe), .radio_rx_i(radio_rx_i),
        .spi_ss_i(spi_ss_i), .spi_clk_i(spi_clk_i), .spi_mosi_i(spi_mosi_i), .spi_miso_o(spi_miso_o),
        .pa_out(pa_out), .pa_oe(pa_oe), .pa_in(pa_in),
        .pb_out(pb_out), .pb_oe(pb_oe), .pb_in(pb_in),
        .dsp_pclk_i(dsp_pclk_i), .dsp_hs_i(dsp_hs_i), .dsp_vs_i(dsp_vs_i), .dsp_de_i(dsp_de_i),
        .dsp_data_i(dsp_data_i), .lcd_pclk_o(lcd_pclk_o), .lcd_hs_o(lcd_hs_o),
        .lcd_vs_o(lcd_vs_o), .lcd_de_o(lcd_de_o), .lcd_data_o(lcd_data_o), .conv_en_o(conv_en_o)
    );

    int n_chk = 0, n_fail = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_q(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_low = 1'b0; wait_q(Q);
        scl = 1'b1; wait_q(Q);
        m_low = 1'b1; wait_q(Q);
        scl = 1'b0; wait_q(Q);
    endtask

    task automatic i2c_stop();
        m_low = 1'b1; wait_q(Q);
        scl = 1'b1; wait_q(Q);
        m_low = 1'b0; wait_q(Q);
    endtask

    task automatic bit_out(input logic b);
        m_low = ~b; wait_q(Q);
        scl = 1'b1; wait_q(Q);
        scl = 1'b0; wait_q(Q);
    endtask

    task automatic bit_in(output logic b);
        m_low = 1'b0; wait_q(Q);
        scl = 1'b1; wait_q(Q / 2);
        b = sda_bus; wait_q(Q - Q / 2);
        scl = 1'b0; wait_q(Q);
    endtask

    task automatic wbyte(input logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(a);
        ack = ~a;
    endtask

    task automatic rbyte(input logic give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            v[i] = b;
        end
        bit_out(~give_ack);
    endtask

    task automatic wr_reg(input logic [6:0] dev, input logic [7:0] loc, input logic [7:0] val, output logic ack);
        logic a1, a2, a3;
        i2c_start();
        wbyte({dev, 1'b0}, a1);
        if (a1) begin
            wbyte(loc, a2);
            wbyte(val, a3);
        end else begin
            a2 = 0; a3 = 0;
        end
        i2c_stop();
        ack = a1 & a2 & a3;
    endtask

    task automatic rd_reg(input logic [7:0] loc, output logic [7:0] v, output logic ack);
        logic a1, a2, a3;
        i2c_start();
        wbyte(8'h82, a1);
        wbyte(loc, a2);
        i2c_start();
        wbyte(8'h83, a3);
        rbyte(1'b0, v);
        i2c_stop();
        ack = a1 & a2 & a3;
    endtask

    function automatic logic [19:0] exp_pads(input logic [3:0] m, input logic tx, input logic rrx,
                                             input logic ss, input logic ck, input logic mo,
                                             input logic [3:0] ai, input logic [3:0] bi);
        logic rtx, rtxe, urx, miso;
        logic [3:0] ao, ae, bo, be;
        rtx = 0; rtxe = 0; urx = 1; miso = 0; ao = 0; ae = 0; bo = 0; be = 0;
        case (m)
            4'd1: begin rtx = tx; rtxe = 1; urx = rrx; end
            4'd2: begin ao = {mo, 1'b0, ck, ss}; ae = 4'b1011; miso = ai[2]; end
            4'd3: begin bo = {1'b0, ss, ck, mo}; be = 4'b0111; miso = bi[3]; end
            4'd4: begin bo = {mo, ck, ss, 1'b0}; be = 4'b1110; miso = bi[0]; end
            default: ;
        endcase
        return {rtx, rtxe, urx, miso, ao, ae, bo, be};
    endfunction

    function automatic string route_req(input logic [3:0] m);
        case (m)
            4'd1: return "R8";
            4'd2: return "R9 R12";
            4'd3: return "R10 R12";
            4'd4: return "R11 R12";
            default: return "R7";
        endcase
    endfunction

    initial begin
        repeat (200000) @(negedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] v, v2;
        wait_q(5);
        rst = 1'b0;
        wait_q(3);

        // R4, R6, R7 reset state at the ports
        check("R4 R7 reset pads", {uart_rx_o, spi_miso_o, radio_tx_oe, pa_oe, pb_oe}, {1'b1, 1'b0, 1'b0, 8'h00});
        dsp_data_i = 24'hFFFFFF;
        wait_q(1);
        check("R4 R6 reset data masked", {lcd_data_o, conv_en_o}, 25'd0);
        check("R13 idle sda released", sda_oe, 1'b0);

        // R3 constants and unmapped
        rd_reg(8'h00, v, ack);
        check("R3 id value", {ack, v}, {1'b1, 8'h61});
        rd_reg(8'hF0, v, ack);
        check("R3 version value", {ack, v}, {1'b1, 8'h01});
        rd_reg(8'h33, v, ack);
        check("R3 unmapped reads zero acked", {ack, v}, {1'b1, 8'h00});
        rd_reg(8'h10, v, ack);
        check("R4 disp reset", v, 8'h00);
        rd_reg(8'h20, v, ack);
        check("R4 route reset", v, 8'h00);

        // R3 writes to read-only locations ignored
        wr_reg(7'h41, 8'h00, 8'h5A, ack);
        rd_reg(8'h00, v, ack);
        check("R3 id write ignored", v, 8'h61);
        wr_reg(7'h41, 8'hF0, 8'h77, ack);
        rd_reg(8'hF0, v, ack);
        check("R3 version write ignored", v, 8'h01);

        // R1 wrong address: no ack, no effect
        wr_reg(7'h42, 8'h20, 8'h02, ack);
        check("R1 foreign address nack", ack, 1'b0);
        wr_reg(7'h40, 8'h10, 8'hFF, ack);
        rd_reg(8'h20, v, ack);
        rd_reg(8'h10, v2, ack);
        check("R1 foreign address no write", {v, v2}, 16'h0000);
        wr_reg(7'h41, 8'h20, 8'h00, ack);
        check("R1 own address ack", ack, 1'b1);

        // R2 multi-byte write lands on the pointer, last byte wins
        i2c_start();
        wbyte(8'h82, ack);
        wbyte(8'h20, ack);
        wbyte(8'h03, ack);
        wbyte(8'hA4, ack);
        i2c_stop();
        rd_reg(8'h20, v, ack);
        check("R2 R4 last byte wins", v, 8'hA4);
        check("R2 R11 route after burst", {pb_oe, pa_oe}, {4'b1110, 4'b0000});

        // R2 repeated read returns same register
        i2c_start();
        wbyte(8'h82, ack);
        wbyte(8'h20, ack);
        i2c_start();
        wbyte(8'h83, ack);
        rbyte(1'b1, v);
        rbyte(1'b0, v2);
        i2c_stop();
        check("R2 repeated read", {v, v2}, 16'hA4A4);

        // R7..R12 sweep all routing values
        for (int m = 0; m < 16; m++) begin
            wr_reg(7'h41, 8'h20, {4'(15 - m), 4'(m)}, ack);
            for (int p = 0; p < 16; p++) begin
                logic [3:0] pv;
                pv = 4'(p);
                uart_tx_i = pv[0]; radio_rx_i = ~pv[0];
                spi_ss_i = pv[1]; spi_clk_i = pv[2]; spi_mosi_i = pv[3];
                pa_in = pv ^ 4'h5; pb_in = ~pv;
                wait_q(2);
                check(route_req(4'(m)),
                      {radio_tx_o, radio_tx_oe, uart_rx_o, spi_miso_o, pa_out, pa_oe, pb_out, pb_oe},
                      exp_pads(4'(m), uart_tx_i, radio_rx_i, spi_ss_i, spi_clk_i, spi_mosi_i, pa_in, pb_in));
            end
        end
        rd_reg(8'h20, v, ack);
        check("R4 route readback", v, 8'h0F);

        // R5, R6 sweep polarity flags and width codes
        for (int i = 0; i < 64; i++) begin
            logic [5:0] iv;
            logic [7:0] dv;
            int w;
            iv = 6'(i);
            dv = {iv[5:2], iv[1:0], 1'b0, iv[0]};
            wr_reg(7'h41, 8'h10, dv, ack);
            case (iv[1:0])
                2'b11: w = 24;
                2'b10: w = 18;
                2'b01: w = 16;
                default: w = 0;
            endcase
            for (int p = 0; p < 2; p++) begin
                logic pb;
                pb = 1'(p);
                dsp_pclk_i = pb; dsp_hs_i = ~pb; dsp_vs_i = pb; dsp_de_i = ~pb;
                dsp_data_i = pb ? 24'hFFFFFF : 24'hA5C3E7;
                wait_q(2);
                check("R5 polarity", {lcd_pclk_o, lcd_hs_o, lcd_vs_o, lcd_de_o},
                      {dsp_pclk_i, dsp_hs_i, dsp_vs_i, dsp_de_i} ^ dv[7:4]);
                check("R6 width mask and enable", {lcd_data_o, conv_en_o},
                      {dsp_data_i & 24'((32'h1 << w) - 1), dv[0]});
            end
        end
        rd_reg(8'h10, v, ack);
        check("R4 disp readback", v, {4'hF, 2'b11, 1'b0, 1'b1});

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule